// File: doc/BRIEF.md
# Delayed Configuration Commit Gate

This block sits between the writable configuration registers of a chip and the registers that actually steer the controlled hardware. Each configuration register has its own fixed settle window, counted in system-clock cycles. When a write reaches a register whose window is closed, the value goes straight to the active copy and a new window opens. Writes that arrive while that window is open are kept in a shadow copy. When the window runs out, the active copy takes the shadow value.

Writes come from one of two sources. The first is a serial front end. It raises a one-cycle strobe at the end of the last data bit of a byte, together with a register index and the data. The second is a bank of parallel control pins with one field per register. When parallel mode is selected, any change in a field counts as a write of the field's new value to that register. Every register has its own counter, so the windows never affect one another.

Top module: `cfg_commit_gate`

## Requirements
- R1: After reset every active field is 0x00, and every `win_open` bit and every `pending` bit is low.
- R2: A write to a register with a closed window shows on that register's active field one cycle after the write edge. At the same point `win_open` rises for that register and `pending` stays low. No window opens when the register's delay is zero.
- R3: A write during an open window leaves the active field unchanged and stores the value as held. `pending` is high exactly when the held value differs from the active value.
- R4: Writes made during an open window do not reload or lengthen it. A window opened by a write at edge t closes at edge t+D, where D is the register's delay.
- R5: At the edge where a window closes, the active field takes the last value written during the window, and `pending` drops.
- R6: A register whose delay is zero applies every write at the next edge, and its `win_open` never rises.
- R7: Each register has its own window. Writes to one register and window activity on one register never change another register's active field, `win_open` or `pending`.
- R8: A write that lands on the final cycle of an open window is applied at once, and a fresh full window starts from that edge.
- R9: With `par_mode` high, a change of field i of `par_pins` (bits i*DATA_W +: DATA_W) between two edges counts as a write of the new field value to register i. A field that stays the same produces no write.
- R10: `ser_wr_stb` is ignored while `par_mode` is high. Pin changes are ignored while `par_mode` is low. Without an enabled write or a closing window, an active field does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_wr_stb | input | 1 | One-cycle pulse marking the end of the final data bit of a serial write |
| ser_wr_addr | input | ADDR_W | Register index for the serial write |
| ser_wr_data | input | DATA_W | Serial write data |
| par_mode | input | 1 | 1 selects the pins as the write source, 0 selects the serial source |
| par_pins | input | NUM_REGS*DATA_W | Parallel control fields, with register i at bits i*DATA_W +: DATA_W |
| active_cfg | output | NUM_REGS*DATA_W | Active values that steer the hardware, packed the same way as `par_pins` |
| win_open | output | NUM_REGS | Per-register flag, high while that register's window is open |
| pending | output | NUM_REGS | Per-register flag, high while a held value differs from the active value |

## Verification
The bound checker watches every cycle for four things:
- `pending` is only ever high inside an open window.
- A window opens and closes with `pending` low.
- A zero-delay register never shows an open window.
- With the serial source selected, an active field changes only after a strobe or while a window was open.

The bench's scenarios are needed to show the exact window length, that a held write does not extend the window, and that the last held value wins. They are also needed to show that a write on the closing cycle restarts the window, that the registers stay separate, and that a pin change acts as a write only in parallel mode.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

    // Which source, if any, delivers a write to a register this cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SER  = 2'd1,
        SRC_PIN  = 2'd2
    } wr_src_e;

    // Select the write source: pins own the registers in parallel mode.
    function automatic wr_src_e pick_src(input logic pin_mode,
                                         input logic ser_hit,
                                         input logic pin_chg);
        if (pin_mode)
            return pin_chg ? SRC_PIN : SRC_NONE;
        return ser_hit ? SRC_SER : SRC_NONE;
    endfunction

endpackage

// File: rtl/cfgc_pin_watch.sv
module cfgc_pin_watch #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned BUS_W   = NUM_REGS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_W-1:0]    pins,
    output logic [NUM_REGS-1:0] chg
);

    typedef struct packed {
        logic [BUS_W-1:0] prev;
    } watch_t;

    watch_t w_d, w_q;

    // The previous sample is tracked in every mode, so entering parallel
    // mode does not create a false edge.
    always_comb begin
        w_d      = w_q;
        w_d.prev = pins;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign chg[g] = (pins[g*DATA_W +: DATA_W] != w_q.prev[g*DATA_W +: DATA_W]);
    end

endmodule

// File: rtl/cfgc_slot.sv
module cfgc_slot #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DELAY  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] active,
    output logic              win_open,
    output logic              pending
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);

    typedef struct packed {
        logic [DATA_W-1:0] active;
        logic [DATA_W-1:0] shadow;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
    } slot_t;

    slot_t s_d, s_q;
    logic  open_w, last_w;

    always_comb begin
        s_d    = s_q;
        open_w = (s_q.cnt != '0);
        last_w = (s_q.cnt == CNT_W'(1));
        if (wr_en && (!open_w || last_w)) begin
            // Closed window, or the closing cycle: apply now and restart.
            s_d.active = wr_data;
            s_d.shadow = wr_data;
            s_d.cnt    = LOAD;
            s_d.pend   = 1'b0;
        end else if (wr_en) begin
            // Window running: hold the value and keep counting down.
            s_d.shadow = wr_data;
            s_d.pend   = (wr_data != s_q.active);
            s_d.cnt    = s_q.cnt - CNT_W'(1);
        end else if (open_w) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (last_w) begin
                s_d.active = s_q.shadow;
                s_d.pend   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active   = s_q.active;
    assign win_open = (s_q.cnt != '0);
    assign pending  = s_q.pend;

endmodule

// File: rtl/cfg_commit_gate.sv
module cfg_commit_gate #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CNT_W    = 8,
    parameter logic [NUM_REGS*CNT_W-1:0] DELAYS = {8'd12, 8'd5, 8'd3, 8'd0},
    localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned BUS_W   = NUM_REGS * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_wr_stb,
    input  logic [ADDR_W-1:0]   ser_wr_addr,
    input  logic [DATA_W-1:0]   ser_wr_data,
    input  logic                par_mode,
    input  logic [BUS_W-1:0]    par_pins,
    output logic [BUS_W-1:0]    active_cfg,
    output logic [NUM_REGS-1:0] win_open,
    output logic [NUM_REGS-1:0] pending
);
    import cfgc_pkg::*;

    logic [NUM_REGS-1:0] pin_chg;

    cfgc_pin_watch #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W)
    ) u_watch (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (par_pins),
        .chg  (pin_chg)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        wr_src_e           src;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;

        always_comb begin
            src     = pick_src(par_mode,
                               ser_wr_stb && (ser_wr_addr == ADDR_W'(g)),
                               pin_chg[g]);
            wr_en   = (src != SRC_NONE);
            wr_data = (src == SRC_PIN) ? par_pins[g*DATA_W +: DATA_W] : ser_wr_data;
        end

        cfgc_slot #(
            .DATA_W(DATA_W),
            .CNT_W (CNT_W),
            .DELAY (int'(DELAYS[g*CNT_W +: CNT_W]))
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .active  (active_cfg[g*DATA_W +: DATA_W]),
            .win_open(win_open[g]),
            .pending (pending[g])
        );
    end

endmodule

// File: rtl/cfgc_checker.sv
module cfgc_checker #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CNT_W    = 8,
    parameter logic [NUM_REGS*CNT_W-1:0] DELAYS = {8'd12, 8'd5, 8'd3, 8'd0},
    localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned BUS_W   = NUM_REGS * DATA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_wr_stb,
    input logic [ADDR_W-1:0]   ser_wr_addr,
    input logic [DATA_W-1:0]   ser_wr_data,
    input logic                par_mode,
    input logic [BUS_W-1:0]    par_pins,
    input logic [BUS_W-1:0]    active_cfg,
    input logic [NUM_REGS-1:0] win_open,
    input logic [NUM_REGS-1:0] pending
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        AST_PEND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            pending[g] |-> win_open[g]); // R3

        AST_OPEN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(win_open[g]) |-> !pending[g]); // R2

        AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(win_open[g]) |-> !pending[g]); // R5

        AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(ser_wr_stb) && !$past(par_mode) && !$past(win_open[g]))
            |-> $stable(active_cfg[g*DATA_W +: DATA_W])); // R10

        if (DELAYS[g*CNT_W +: CNT_W] == '0) begin : g_zero
            AST_ZERO_NEVER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
                !win_open[g]); // R6
        end
    end

endmodule

bind cfg_commit_gate cfgc_checker #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .DELAYS  (DELAYS)
) u_cfgc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_wr_stb (ser_wr_stb),
    .ser_wr_addr(ser_wr_addr),
    .ser_wr_data(ser_wr_data),
    .par_mode   (par_mode),
    .par_pins   (par_pins),
    .active_cfg (active_cfg),
    .win_open   (win_open),
    .pending    (pending)
);

// File: tb/test_cfg_commit_gate.sv
module test_cfg_commit_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;
    localparam int DW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ser_wr_stb = 1'b0;
    logic [1:0]     ser_wr_addr = '0;
    logic [DW-1:0]  ser_wr_data = '0;
    logic           par_mode = 1'b0;
    logic [NR*DW-1:0] par_pins = '0;
    logic [NR*DW-1:0] active_cfg;
    logic [NR-1:0]  win_open;
    logic [NR-1:0]  pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_commit_gate i_cfg_commit_gate (
        .clk(clk), .rst_n(rst_n),
        .ser_wr_stb(ser_wr_stb), .ser_wr_addr(ser_wr_addr), .ser_wr_data(ser_wr_data),
        .par_mode(par_mode), .par_pins(par_pins),
        .active_cfg(active_cfg), .win_open(win_open), .pending(pending)
    );

    // Delays: reg0=0, reg1=3, reg2=5, reg3=12.
    typedef struct packed {
        logic          stb;
        logic [1:0]    addr;
        logic [DW-1:0] data;
        logic [DW-1:0] exp_act;
        logic          exp_win;
        logic          exp_pend;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b1, 2'd0, 8'hA0, 8'hA0, 1'b0, 1'b0, 4'd6}, // R6 immediate
        '{1'b1, 2'd0, 8'hA1, 8'hA1, 1'b0, 1'b0, 4'd6}, // R6 back to back
        '{1'b1, 2'd1, 8'h11, 8'h11, 1'b1, 1'b0, 4'd2}, // R2 open window
        '{1'b1, 2'd1, 8'h22, 8'h11, 1'b1, 1'b1, 4'd3}, // R3 held
        '{1'b0, 2'd1, 8'h00, 8'h11, 1'b1, 1'b1, 4'd4}, // R4 still open
        '{1'b0, 2'd1, 8'h00, 8'h22, 1'b0, 1'b0, 4'd5}, // R5 commit at t+3
        '{1'b1, 2'd1, 8'h33, 8'h33, 1'b1, 1'b0, 4'd2}, // R2
        '{1'b1, 2'd1, 8'h33, 8'h33, 1'b1, 1'b0, 4'd3}, // R3 same value
        '{1'b1, 2'd1, 8'h44, 8'h33, 1'b1, 1'b1, 4'd3}, // R3
        '{1'b1, 2'd1, 8'h55, 8'h55, 1'b1, 1'b0, 4'd8}, // R8 closing-cycle write
        '{1'b0, 2'd1, 8'h00, 8'h55, 1'b1, 1'b0, 4'd8}, // R8 fresh window
        '{1'b0, 2'd1, 8'h00, 8'h55, 1'b1, 1'b0, 4'd8},
        '{1'b0, 2'd1, 8'h00, 8'h55, 1'b0, 1'b0, 4'd4}  // R4 closes
    };

    function automatic logic [DW-1:0] fld(input int i);
        return active_cfg[i*DW +: DW];
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "active", active_cfg, '0);
        chk("R1", "win_open", win_open, '0);
        chk("R1", "pending", pending, '0);
        rst_n = 1'b1;

        foreach (VECS[k]) begin
            ser_wr_stb  = VECS[k].stb;
            ser_wr_addr = VECS[k].addr;
            ser_wr_data = VECS[k].data;
            tick();
            chk($sformatf("R%0d", VECS[k].req), $sformatf("vec%0d active", k), fld(VECS[k].addr), VECS[k].exp_act);
            chk($sformatf("R%0d", VECS[k].req), $sformatf("vec%0d win", k), win_open[VECS[k].addr], VECS[k].exp_win);
            chk($sformatf("R%0d", VECS[k].req), $sformatf("vec%0d pend", k), pending[VECS[k].addr], VECS[k].exp_pend);
        end
        ser_wr_stb = 1'b0;

        // R7: independent windows on reg2 (D=5) and reg3 (D=12)
        ser_wr_stb = 1'b1; ser_wr_addr = 2'd2; ser_wr_data = 8'h21; tick();
        ser_wr_addr = 2'd3; ser_wr_data = 8'h31; tick();
        ser_wr_addr = 2'd2; ser_wr_data = 8'h22; tick();
        ser_wr_stb = 1'b0;
        chk("R7", "reg3 untouched by reg2 hold", fld(3), 8'h31);
        chk("R7", "reg3 pending", pending[3], 1'b0);
        tick(); tick();
        chk("R3", "reg2 held", fld(2), 8'h21);
        chk("R3", "reg2 pending", pending[2], 1'b1);
        tick();
        chk("R5", "reg2 commit", fld(2), 8'h22);
        chk("R7", "reg2 closed", win_open[2], 1'b0);
        chk("R7", "reg3 still open", win_open[3], 1'b1);
        chk("R7", "reg1 unaffected", fld(1), 8'h55);
        // R4 on reg3: held write does not extend the window
        ser_wr_stb = 1'b1; ser_wr_addr = 2'd3; ser_wr_data = 8'h32; tick();
        ser_wr_stb = 1'b0;
        repeat (6) tick();
        chk("R4", "reg3 open before t+12", win_open[3], 1'b1);
        chk("R4", "reg3 not yet applied", fld(3), 8'h31);
        tick();
        chk("R4", "reg3 closes at t+12", win_open[3], 1'b0);
        chk("R5", "reg3 last value", fld(3), 8'h32);

        // R10: pin change ignored in serial mode
        par_pins[0*DW +: DW] = 8'h99; tick();
        chk("R10", "pin ignored in serial mode", fld(0), 8'hA1);
        // R9: entering parallel mode with unchanged pins is no write
        par_mode = 1'b1; tick();
        chk("R9", "no edge no write", fld(0), 8'hA1);
        par_pins[0*DW +: DW] = 8'h5A; tick();
        chk("R9", "pin edge writes reg0", fld(0), 8'h5A);
        // R9/R10: change field1, serial strobe to reg0 ignored
        par_pins[1*DW +: DW] = 8'h77;
        ser_wr_stb = 1'b1; ser_wr_addr = 2'd0; ser_wr_data = 8'h01; tick();
        ser_wr_stb = 1'b0;
        chk("R9", "pin edge writes reg1", fld(1), 8'h77);
        chk("R9", "reg1 window opens", win_open[1], 1'b1);
        chk("R10", "serial ignored in parallel mode", fld(0), 8'h5A);
        chk("R9", "unchanged field no write", fld(2), 8'h22);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule